// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Generator

This block drives three motor phases with complementary pulse-width modulation on a symmetric triangle carrier. A single up/down counter forms the trailing carrier, which runs from zero up to the period minus the dead time and back down. The leading carrier is the same count plus the dead time, so it spans the dead time up to the period. Each phase compares its duty value against both carriers. The positive output is switched by matches on the trailing carrier and the negative output by matches on the leading carrier, so the two are never on together and a dead-time gap opens around every edge. A duty of zero holds the positive output on for the whole carrier. A duty equal to the period holds it off.

The period, dead-time and duty inputs are sampled only at the carrier trough, so a value written mid-cycle takes effect cleanly on the next cycle. When a phase would see its turn-on and turn-off matches in the same clock, as happens at the crest for some duty values, both are dropped and the output keeps its level. A separate sync-toggle output can be enabled. It flips at every crest and every trough, which makes it a square wave locked to the carrier.

Top module: `cpwm_gen`

## Requirements
- R1: With period P and dead time D (configuration rule: 1 <= D < P), the trailing count steps by one per clock from 0 up to M = P - D and back to 0. The carrier repeats every 2M clocks. The leading count always equals the trailing count plus D.
- R2: For 0 < duty < M, the positive output of a phase is high for exactly 2(M - duty) clocks of each carrier.
- R3: A duty of 0 holds the positive output at 1 and the negative output at 0 for the whole carrier (100% duty).
- R4: A duty equal to P holds the positive output at 0 and the negative output at 1 for the whole carrier (0% duty).
- R5: When turn-on and turn-off matches of one output fall in the same clock (at the crest, when duty = M for the positive output or duty = P for the negative output), both are ignored and the output keeps its level. So duty = M gives a positive output that stays low.
- R6: For duty <= P, the negative output is high for exactly 2·max(duty - D, 0) clocks of each carrier.
- R7: The positive and negative outputs of a phase are never high together. For D < duty < M, each carrier has 2D clocks where both are low.
- R8: Period, dead time and duty are sampled only in the trough clock. A change made mid-carrier first shows on the outputs in the clock after the next trough.
- R9: While the toggle enable is 1, the toggle output inverts in the clock after each crest and after each trough. The first inversion follows the first trough after start.
- R10: The toggle output is 1 after reset, and it is 1 in the clock after the toggle enable goes from 0 to 1.
- R11: While the toggle enable is 0 and the carrier runs, the toggle output keeps its level.
- R12: While the run input is 0, the carrier is stopped. From the next clock, all six phase outputs are 0 and the toggle output is 1. After the run input returns to 1, the counter restarts with one idle clock followed by a trough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Carrier run enable (0 stops counters and idles outputs) |
| period_i | input | CW | Period value P, sampled at trough |
| dead_i | input | CW | Dead-time value D, sampled at trough |
| duty_i | input | NPH·CW | Duty values, phase k in bits [k·CW +: CW], sampled at trough |
| tgl_en_i | input | 1 | Sync-toggle enable |
| pos_o | output | NPH | Positive-phase outputs, bit k is phase k |
| neg_o | output | NPH | Negative-phase outputs, bit k is phase k |
| tgl_o | output | 1 | Carrier-synchronous toggle output |

## Verification
Every output is a register fed from the carrier state, so each result appears one clock after the counter state that causes it. Once run_i is raised, the first clock edge is idle and the second edge is the first trough. Its initial levels are therefore seen after that second edge, and the next trough is processed 2M edges later. The bench drives inputs on falling edges and counts falling edges from the one where run_i rose. It samples exactly at the edge numbers these latencies give: the last clock before the trough and the first clock after it for the sampling check, and the clocks after edges 1, 18 and 35 for the toggle. Duty results are checked as high-clock counts over a window of exactly 2M samples taken after the carrier has settled, so the count does not depend on where the window starts.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Pair of edge requests reaching one output register in a clock.
  typedef struct packed {
    logic set;
    logic clr;
  } edge_req_t;

  // Next level of a switched output: a lone request wins;
  // none, or both together, keep the present level.
  function automatic logic resolve_edge(input logic cur, input edge_req_t req);
    logic nxt;
    nxt = cur;
    if (req.set && !req.clr) nxt = 1'b1;
    if (req.clr && !req.set) nxt = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] dead_i,
  output logic          act_o,
  output logic          trough_o,
  output logic          crest_o,
  output logic          up_o,
  output logic [CW-1:0] trail_o,
  output logic [CW-1:0] lead_o
);

  // Top of the trailing carrier: period minus dead time.
  function automatic logic [CW-1:0] span(input logic [CW-1:0] per, input logic [CW-1:0] dt);
    return per - dt;
  endfunction

  logic          act_q;
  logic          up_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] per_q;
  logic [CW-1:0] dead_q;
  logic [CW-1:0] top_s;
  logic [CW-1:0] top_new;
  logic [CW-1:0] top_eff;
  logic [CW-1:0] cnt_nxt;
  logic          up_nxt;

  assign top_s    = span(per_q, dead_q);
  assign top_new  = span(period_i, dead_i);
  assign trough_o = act_q && (cnt_q == '0);
  assign crest_o  = act_q && (cnt_q == top_s) && (cnt_q != '0);
  // the trough starts a new carrier with freshly sampled limits
  assign top_eff  = trough_o ? top_new : top_s;
  assign cnt_nxt  = up_q ? cnt_q + CW'(1) : cnt_q - CW'(1);
  assign up_nxt   = up_q ? (cnt_nxt != top_eff) : (cnt_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      up_q   <= 1'b1;
      cnt_q  <= '0;
      per_q  <= '0;
      dead_q <= '0;
    end else if (!run_i) begin
      act_q <= 1'b0;
      up_q  <= 1'b1;
      cnt_q <= '0;
    end else if (!act_q) begin
      act_q <= 1'b1;
      up_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
      if (trough_o) begin
        per_q  <= period_i;
        dead_q <= dead_i;
      end
    end
  end

  assign act_o   = act_q;
  assign up_o    = up_q;
  assign trail_o = cnt_q;
  assign lead_o  = cnt_q + dead_q;

  AST_SPAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !trough_o) |-> (cnt_q <= top_s));  // R1
  AST_CREST_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (crest_o && run_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));  // R1
  AST_STOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!act_q && cnt_q == '0));  // R12

endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          act_i,
  input  logic          trough_i,
  input  logic          crest_i,
  input  logic          up_i,
  input  logic [CW-1:0] trail_i,
  input  logic [CW-1:0] lead_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] dead_i,
  output logic          pos_o,
  output logic          neg_o
);

  logic [CW-1:0] duty_q;
  logic          pos_q;
  logic          neg_q;
  logic          pos_hit;
  logic          neg_hit;
  edge_req_t     pos_req;
  edge_req_t     neg_req;

  // Matches are taken on the rising or falling slope; the crest
  // belongs to both slopes, so a crest match requests both edges.
  assign pos_hit = !trough_i && (trail_i == duty_q);
  assign neg_hit = !trough_i && (lead_i == duty_q);
  assign pos_req = '{set: pos_hit && (up_i || crest_i),
                     clr: pos_hit && (!up_i || crest_i)};
  assign neg_req = '{set: neg_hit && (!up_i || crest_i),
                     clr: neg_hit && (up_i || crest_i)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      pos_q  <= 1'b0;
      neg_q  <= 1'b0;
    end else if (!run_i || !act_i) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else if (trough_i) begin
      duty_q <= duty_i;
      pos_q  <= (duty_i == '0);
      neg_q  <= (duty_i > dead_i);
    end else begin
      pos_q <= resolve_edge(pos_q, pos_req);
      neg_q <= resolve_edge(neg_q, neg_req);
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_q && neg_q));  // R7
  AST_POS_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && act_i && !trough_i && pos_req.set && pos_req.clr) |=> $stable(pos_q));  // R5
  AST_NEG_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && act_i && !trough_i && neg_req.set && neg_req.clr) |=> $stable(neg_q));  // R5
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && trough_i && duty_i == '0) |=> (pos_q && !neg_q));  // R3
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!pos_q && !neg_q));  // R12

endmodule

// File: rtl/cpwm_sync_toggle.sv
module cpwm_sync_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic act_i,
  input  logic crest_i,
  input  logic trough_i,
  input  logic en_i,
  output logic tgl_o
);

  logic en_q;
  logic tgl_q;
  logic en_rise;
  logic flip;

  assign en_rise = en_i && !en_q;
  assign flip    = en_i && (crest_i || trough_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tgl_q <= 1'b1;
    end else begin
      en_q <= en_i;
      if (!run_i || !act_i) tgl_q <= 1'b1;
      else if (en_rise)     tgl_q <= 1'b1;
      else if (flip)        tgl_q <= ~tgl_q;
    end
  end

  assign tgl_o = tgl_q;

  AST_TGL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> tgl_q);  // R10
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && act_i && en_i && en_q && (crest_i || trough_i)) |=> (tgl_q != $past(tgl_q)));  // R9
  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && act_i && !en_i) |=> $stable(tgl_q));  // R11
  AST_TGL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> tgl_q);  // R12

endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen #(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CW-1:0]     period_i,
  input  logic [CW-1:0]     dead_i,
  input  logic [NPH*CW-1:0] duty_i,
  input  logic              tgl_en_i,
  output logic [NPH-1:0]    pos_o,
  output logic [NPH-1:0]    neg_o,
  output logic              tgl_o
);

  logic          act;
  logic          trough;
  logic          crest;
  logic          up;
  logic [CW-1:0] trail;
  logic [CW-1:0] lead;

  cpwm_carrier #(.CW(CW)) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .period_i (period_i),
    .dead_i   (dead_i),
    .act_o    (act),
    .trough_o (trough),
    .crest_o  (crest),
    .up_o     (up),
    .trail_o  (trail),
    .lead_o   (lead)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    cpwm_phase #(.CW(CW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_i),
      .act_i    (act),
      .trough_i (trough),
      .crest_i  (crest),
      .up_i     (up),
      .trail_i  (trail),
      .lead_i   (lead),
      .duty_i   (duty_i[k*CW +: CW]),
      .dead_i   (dead_i),
      .pos_o    (pos_o[k]),
      .neg_o    (neg_o[k])
    );
  end

  cpwm_sync_toggle u_toggle (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .act_i    (act),
    .crest_i  (crest),
    .trough_i (trough),
    .en_i     (tgl_en_i),
    .tgl_o    (tgl_o)
  );

  AST_CREST_TROUGH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(crest && trough));  // R1

endmodule

// File: tb/test_cpwm_gen.sv
`timescale 1ns/1ps
module test_cpwm_gen;
  localparam int CW  = 16;
  localparam int NPH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              run = 1'b0;
  logic              tgl_en = 1'b0;
  logic [CW-1:0]     per = CW'(20);
  logic [CW-1:0]     dead = CW'(3);
  logic [NPH*CW-1:0] duty = '0;
  logic [NPH-1:0]    pos;
  logic [NPH-1:0]    neg;
  logic              tgl;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cpwm_gen #(.CW(CW), .NPH(NPH)) i_cpwm_gen (
    .clk(clk), .rst_n(rst_n), .run_i(run), .period_i(per), .dead_i(dead),
    .duty_i(duty), .tgl_en_i(tgl_en), .pos_o(pos), .neg_o(neg), .tgl_o(tgl)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic restart(input int p, input int d, input int d0, input int d1, input int d2, input bit en);
    @(negedge clk);
    run    = 1'b0;
    per    = CW'(p);
    dead   = CW'(d);
    duty   = {CW'(d2), CW'(d1), CW'(d0)};
    tgl_en = en;
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic measure(input int win, output int ph[NPH], output int nh[NPH], output int ovl);
    for (int k = 0; k < NPH; k++) begin ph[k] = 0; nh[k] = 0; end
    ovl = 0;
    for (int s = 0; s < win; s++) begin
      @(negedge clk);
      for (int k = 0; k < NPH; k++) begin
        ph[k] += int'(pos[k]);
        nh[k] += int'(neg[k]);
        if (pos[k] && neg[k]) ovl++;
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R12", "pos in reset", int'(pos), 0);
    check("R12", "neg in reset", int'(neg), 0);
    check("R10", "toggle in reset", int'(tgl), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_mid_duty;
    int ph[NPH]; int nh[NPH]; int ovl;
    restart(20, 3, 5, 10, 15, 1'b0);
    repeat (40) @(negedge clk);
    measure(34, ph, nh, ovl);
    check("R2", "pos highs duty5", ph[0], 24);
    check("R2", "pos highs duty10", ph[1], 14);
    check("R2", "pos highs duty15", ph[2], 4);
    check("R6", "neg highs duty5", nh[0], 4);
    check("R6", "neg highs duty10", nh[1], 14);
    check("R6", "neg highs duty15", nh[2], 24);
    check("R7", "overlap clocks", ovl, 0);
    check("R7", "active clocks duty10", ph[1] + nh[1], 34 - 6);
  endtask

  task automatic t_extremes;
    int ph[NPH]; int nh[NPH]; int ovl;
    restart(20, 3, 0, 20, 17, 1'b0);
    repeat (40) @(negedge clk);
    measure(34, ph, nh, ovl);
    check("R3", "pos highs duty0", ph[0], 34);
    check("R3", "neg highs duty0", nh[0], 0);
    check("R4", "pos highs duty=P", ph[1], 0);
    check("R4", "neg highs duty=P", nh[1], 34);
    check("R5", "pos highs duty=M", ph[2], 0);
    check("R6", "neg highs duty=M", nh[2], 28);
    check("R7", "overlap clocks extremes", ovl, 0);
  endtask

  task automatic t_short_period;
    int ph[NPH]; int nh[NPH]; int ovl;
    restart(8, 2, 1, 4, 6, 1'b0);
    repeat (20) @(negedge clk);
    measure(12, ph, nh, ovl);
    check("R1", "pos highs P8 D2 duty1", ph[0], 10);
    check("R2", "pos highs P8 D2 duty4", ph[1], 4);
    check("R5", "pos highs P8 D2 duty=M", ph[2], 0);
    check("R6", "neg highs P8 D2 duty1", nh[0], 0);
    check("R6", "neg highs P8 D2 duty4", nh[1], 4);
    check("R6", "neg highs P8 D2 duty6", nh[2], 8);
  endtask

  task automatic t_trough_sampling;
    restart(20, 3, 0, 0, 0, 1'b0);
    repeat (11) @(negedge clk);
    duty[CW-1:0] = CW'(17);
    repeat (24) @(negedge clk);
    check("R8", "pos before next trough", int'(pos[0]), 1);
    check("R8", "neg before next trough", int'(neg[0]), 0);
    @(negedge clk);
    check("R8", "pos after next trough", int'(pos[0]), 0);
    check("R8", "neg after next trough", int'(neg[0]), 1);
  endtask

  task automatic t_toggle;
    int flips; logic prev;
    restart(20, 3, 5, 5, 5, 1'b1);
    @(negedge clk);
    check("R10", "toggle idle clock", int'(tgl), 1);
    @(negedge clk);
    check("R9", "toggle after first trough", int'(tgl), 0);
    repeat (16) @(negedge clk);
    check("R9", "toggle before crest", int'(tgl), 0);
    @(negedge clk);
    check("R9", "toggle after crest", int'(tgl), 1);
    repeat (17) @(negedge clk);
    check("R9", "toggle after second trough", int'(tgl), 0);
    flips = 0; prev = tgl;
    for (int s = 0; s < 68; s++) begin
      @(negedge clk);
      if (tgl != prev) flips++;
      prev = tgl;
    end
    check("R1,R9", "toggle flips in 4M clocks", flips, 4);
    tgl_en = 1'b0;
    flips = 0; prev = tgl;
    for (int s = 0; s < 68; s++) begin
      @(negedge clk);
      if (tgl != prev) flips++;
      prev = tgl;
    end
    check("R11", "toggle flips while disabled", flips, 0);
    check("R11", "toggle level while disabled", int'(tgl), 0);
    tgl_en = 1'b1;
    @(negedge clk);
    check("R10", "toggle after enable rise", int'(tgl), 1);
  endtask

  task automatic t_stop;
    restart(20, 3, 0, 20, 0, 1'b1);
    repeat (2) @(negedge clk);
    check("R12", "toggle low before stop", int'(tgl), 0);
    check("R12", "pos high before stop", int'(pos), 3'b101);
    check("R12", "neg high before stop", int'(neg), 3'b010);
    run = 1'b0;
    @(negedge clk);
    check("R12", "pos after stop", int'(pos), 0);
    check("R12", "neg after stop", int'(neg), 0);
    check("R12", "toggle after stop", int'(tgl), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_mid_duty();
    t_extremes();
    t_short_period();
    t_trough_sampling();
    t_toggle();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule